// File: doc/BRIEF.md
# Key-Guarded Register Page Selector

This block keeps a few critical control registers behind a two-byte key. The register space has two pages, a normal one and an alternate one, and a page-select register chooses between them. That page-select register is itself guarded. A pin-routing register that is visible only on the alternate page is guarded in the same way. Its bit 1 steers a port pin to a PWM output.

Software unlocks the guard by writing two fixed values to a dedicated key register. The first value is 0xAA and the second is 0x55. After that, exactly one write to a guarded register is accepted, and only if it arrives within a short window. The lock then closes again. Writes to guarded registers at any other time are dropped without any effect. Reads are never restricted. Each page change needs its own unlock, both going to the alternate page and coming back.

The bus is a plain single-cycle register port: address, write data, write strobe, and combinational read data. The current page and the routing register value are also brought out as outputs.

Top module: `guarded_page_regs`

## Requirements
- R1: After reset the block is locked, `pageSel` is 0, `pinRoute` is 0, and a read of the page register (address 0x11) returns 0.
- R2: Writing 0xAA and then 0x55 to the key register (address 0x10) opens the guard. A following write to the page register then sets the page to the value of write-data bit 0, with 1 meaning the alternate page.
- R3: A write to the page register while the guard is closed is ignored, and the page keeps its value.
- R4: An opened guard accepts only one guarded write. A second guarded write without a new unlock is ignored.
- R5: Returning from the alternate page to the normal page also needs a full unlock sequence.
- R6: The guarded write must be sampled at one of the 4 clock edges that follow the edge that took the 0x55 key. A write at the 5th edge or later is ignored.
- R7: A key-register write that breaks the 0xAA-then-0x55 order closes the guard. Examples are a value other than 0x55 after 0xAA, or 0x55 without a preceding 0xAA.
- R8: A key write of 0xAA always restarts the sequence, so the order 0xAA, 0xAA, 0x55 opens the guard.
- R9: The routing register (address 0x20) exists only on the alternate page. On the normal page, a write to 0x20 has no effect and a read of 0x20 returns 0.
- R10: On the alternate page, the routing register accepts a write only inside an open guard. Its bit 1 drives `pwmOnPin`.
- R11: Reads of the page and routing registers return their contents whether the guard is open or closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| pageSel | output | 1 | Current page: 0 normal, 1 alternate |
| pinRoute | output | 8 | Routing register contents |
| pwmOnPin | output | 1 | Routing bit 1: pin steered to PWM |

## Verification
The unlock logic is driven with several key sequences:
- the correct pair;
- a repeated first byte;
- a wrong second byte;
- the second byte alone.

Only the correct pair and the repeated first byte may let a following guarded write take effect. The window is probed with a write at the last edge it allows and with one a cycle later, which separates an off-by-one counter from a correct one. Guarded writes are also issued while closed, twice after a single unlock, and to the routing address on each page. These show whether a write is correctly dropped, consumed once, or decoded against the page.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    LOCKED  = 2'd0,
    GOT_KEY1 = 2'd1,
    OPEN    = 2'd2
  } gprStateT;

  typedef struct packed {
    logic pageWr;
    logic routeWr;
  } gprStrobeT;

endpackage

// File: rtl/gpr_unlock_ctrl.sv
module gpr_unlock_ctrl
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] PAGE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = 8'h20,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              pageNow,
  output gprStrobeT         strobes
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  gprStateT   state, stateNext;
  logic [CNT_W-1:0] winCnt, winCntNext;

  logic keyWr, pageHit, routeHit, guardedWr, grant;

  assign keyWr     = busWe && (busAddr == KEY_ADDR);
  assign pageHit   = busWe && (busAddr == PAGE_ADDR);
  assign routeHit  = busWe && (busAddr == ROUTE_ADDR) && pageNow;
  assign guardedWr = pageHit || routeHit;
  assign grant     = (state == OPEN) && guardedWr;

  always_comb begin
    stateNext  = state;
    winCntNext = winCnt;
    if (keyWr) begin
      if (busWdata == KEY_FIRST) begin
        stateNext = GOT_KEY1;
      end else if (state == GOT_KEY1 && busWdata == KEY_SECOND) begin
        stateNext  = OPEN;
        winCntNext = CNT_W'(WINDOW);
      end else begin
        stateNext = LOCKED;
      end
    end else if (state == OPEN) begin
      if (guardedWr || winCnt == CNT_W'(1)) begin
        stateNext = LOCKED;
      end else begin
        winCntNext = winCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= LOCKED;
      winCnt <= '0;
    end else begin
      state  <= stateNext;
      winCnt <= winCntNext;
    end
  end

  assign strobes.pageWr  = grant && pageHit;
  assign strobes.routeWr = grant && routeHit;

  // R2: the guard opens only right after the second key byte
  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == OPEN && $past(state) != OPEN) |->
      ($past(state) == GOT_KEY1 && $past(keyWr) && $past(busWdata) == KEY_SECOND));

  // R4: a granted write always closes the guard
  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pageWr || strobes.routeWr) |=> state != OPEN);

  // R6: an open window always has a live, bounded count
  p_window_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == OPEN |-> (winCnt != '0 && winCnt <= CNT_W'(WINDOW)));

  // R7: a wrong key byte closes the guard
  p_bad_key_locks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && busWdata != KEY_FIRST && busWdata != KEY_SECOND) |=> state == LOCKED);

endmodule

// File: rtl/gpr_reg_file.sv
module gpr_reg_file
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  gprStrobeT         strobes,
  output logic [DATA_W-1:0] busRdata,
  output logic              pageQ,
  output logic [DATA_W-1:0] routeQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ  <= 1'b0;
      routeQ <= '0;
    end else begin
      if (strobes.pageWr)  pageQ  <= busWdata[0];
      if (strobes.routeWr) routeQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == PAGE_ADDR)                 busRdata = {{(DATA_W-1){1'b0}}, pageQ};
    else if (busAddr == ROUTE_ADDR && pageQ)  busRdata = routeQ;
  end

  // R3: the page bit only moves on a granted strobe
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pageWr |=> $stable(pageQ));

  // R10: routing register only moves on a granted strobe
  p_route_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.routeWr |=> $stable(routeQ));

  // R9: routing strobe only while the alternate page is selected
  p_route_alt_page_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.routeWr |-> pageQ);

  // R4: never both guarded registers in one cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.pageWr, strobes.routeWr}));

endmodule

// File: rtl/guarded_page_regs.sv
module guarded_page_regs
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] PAGE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = 8'h20,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  output logic              pageSel,
  output logic [DATA_W-1:0] pinRoute,
  output logic              pwmOnPin
);

  gprStrobeT strobes;
  logic      pageQ;
  logic [DATA_W-1:0] routeQ;

  gpr_unlock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW(WINDOW),
    .KEY_ADDR(KEY_ADDR), .PAGE_ADDR(PAGE_ADDR), .ROUTE_ADDR(ROUTE_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .pageNow(pageQ), .strobes(strobes)
  );

  gpr_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_ADDR(PAGE_ADDR), .ROUTE_ADDR(ROUTE_ADDR)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strobes(strobes), .busRdata(busRdata), .pageQ(pageQ), .routeQ(routeQ)
  );

  assign pageSel  = pageQ;
  assign pinRoute = routeQ;
  assign pwmOnPin = routeQ[1];

endmodule

// File: tb/guarded_page_regs_bench.sv
module guarded_page_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_KEY = 8'h10, A_PAGE = 8'h11, A_ROUTE = 8'h20;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic [7:0] busRdata, pinRoute;
  logic pageSel, pwmOnPin;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guarded_page_regs u_guarded_page_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pageSel(pageSel),
    .pinRoute(pinRoute), .pwmOnPin(pwmOnPin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    busWe = 1'b0; busAddr = a; #1; d = busRdata;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55);
  endtask

  task automatic setPage(input logic p);
    unlock(); wr(A_PAGE, {7'd0, p});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 page", pageSel, 0);
    chk("R1 route", pinRoute, 0);
    rd(A_PAGE, d); chk("R1 read page", d, 0);
  endtask

  task automatic t_locked_write();
    wr(A_PAGE, 8'h01);
    chk("R3 locked page write", pageSel, 0);
  endtask

  task automatic t_unlock_switch();
    setPage(1'b1);
    chk("R2 switch to alternate", pageSel, 1);
    wr(A_PAGE, 8'h00);
    chk("R4 second write ignored", pageSel, 1);
    setPage(1'b0);
    chk("R5 back to normal with unlock", pageSel, 0);
  endtask

  task automatic t_window();
    unlock(); idle(3); wr(A_PAGE, 8'h01);
    chk("R6 write at last window edge", pageSel, 1);
    unlock(); idle(4); wr(A_PAGE, 8'h00);
    chk("R6 write after window", pageSel, 1);
    setPage(1'b0);
    chk("R6 restore", pageSel, 0);
  endtask

  task automatic t_bad_order();
    wr(A_KEY, 8'hAA); wr(A_KEY, 8'h12); wr(A_KEY, 8'h55); wr(A_PAGE, 8'h01);
    chk("R7 wrong middle byte", pageSel, 0);
    wr(A_KEY, 8'h55); wr(A_PAGE, 8'h01);
    chk("R7 second byte alone", pageSel, 0);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_PAGE, 8'h01);
    chk("R7 reversed order", pageSel, 0);
    wr(A_KEY, 8'hAA); wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_PAGE, 8'h01);
    chk("R8 repeated first byte", pageSel, 1);
  endtask

  task automatic t_route();
    logic [7:0] d;
    // page is alternate here
    wr(A_ROUTE, 8'h02);
    chk("R10 locked route write", pinRoute, 0);
    unlock(); wr(A_ROUTE, 8'h02);
    chk("R10 route written", pinRoute, 8'h02);
    chk("R10 pwm steered", pwmOnPin, 1);
    rd(A_ROUTE, d); chk("R11 read route while locked", d, 8'h02);
    rd(A_PAGE, d);  chk("R11 read page while locked", d, 1);
    setPage(1'b0);
    rd(A_ROUTE, d); chk("R9 route hidden on normal page", d, 0);
    unlock(); wr(A_ROUTE, 8'h00);
    chk("R9 route write on normal page", pinRoute, 8'h02);
    wr(A_PAGE, 8'h01);
    chk("R9 unlock not consumed by hidden address", pageSel, 1);
    setPage(1'b0);
    chk("R5 final return", pageSel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_write();
    t_unlock_switch();
    t_window();
    t_bad_order();
    t_route();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule